// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column addresses for one SDRAM read or write burst, one address per clock. A mode register is loaded from the address bus by a mode-register-set strobe. The strobe is taken only while the all-banks-idle input is high. From the stored fields the block decodes the burst length and the addressing order. When a burst-start pulse arrives, the block emits the column sequence beginning at the given start column. Each sequence wraps inside its length-aligned block and never carries into the higher address bits.

Two orders are supported: sequential (incrementing) and interleaved (low bits XOR beat index). A full-page length runs in sequential order through a 512-column space until a terminate pulse ends it. Burst-length codes that have no meaning, and the pairing of interleaved order with full page, raise an illegal flag. Any burst started under such a code runs for a single beat.

A CAS latency field is stored alongside the other fields and exported. It has no effect on sequencing. The controller around the block uses `valid_o` and `last_o` to frame the column commands it issues.

Top module: `sdram_burst_colgen`

## Requirements
- R1: When `mrs_i` and `banks_idle_i` are both high at a clock edge, `addr_i` is stored in the mode register. It appears on `mode_o` after that edge, and `cas_lat_o` shows mode bits 6..4.
- R2: After reset the mode register is zero. A `mrs_i` pulse with `banks_idle_i` low leaves `mode_o` unchanged.
- R3: Mode bits 2..0 set the burst length: 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8 and 111 gives full page. Mode bit 3 selects the order: 0 is sequential and 1 is interleaved.
- R4: In sequential order with length L, beat k carries the start column's bits above log2(L) unchanged. Its low log2(L) bits are (start low bits + k) mod L.
- R5: In interleaved order with length L, beat k carries the start column with its low log2(L) bits XORed with k.
- R6: In full-page mode the column increments by one per beat and wraps from 511 to 0. The burst continues until `term_i` is high on a beat. That beat has `last_o` high, and `valid_o` is low on the next cycle.
- R7: Codes 100, 101 and 110, and code 111 with bit 3 set, drive `mode_illegal_o` high. A burst started under any of them is one beat long.
- R8: A `start_i` pulse at a clock edge puts beat 0 (the start column) on `col_o` with `valid_o` high after that edge. One beat follows per clock, and `valid_o` stays high for exactly L cycles of a fixed-length burst.
- R9: `last_o` is high on the final beat of a fixed-length burst and low on all earlier beats. `valid_o` is low on the following cycle.
- R10: A `start_i` pulse during an active burst aborts it. The next cycle shows beat 0 of the new burst.
- R11: `term_i` high on a beat of a fixed-length burst makes that beat the last one.
- R12: Length and order are captured when a burst starts. A mode-register write during the burst does not change the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mrs_i | input | 1 | Mode-register-set strobe |
| banks_idle_i | input | 1 | All banks idle; gates `mrs_i` |
| addr_i | input | 10 | Address bus, source of mode register data |
| start_i | input | 1 | Burst-start pulse |
| start_col_i | input | 9 | Start column for the burst |
| term_i | input | 1 | Burst-terminate pulse |
| col_o | output | 9 | Column address of the current beat |
| valid_o | output | 1 | A beat is present on `col_o` |
| last_o | output | 1 | Current beat is the final one |
| mode_o | output | 10 | Mode register contents |
| cas_lat_o | output | 3 | Stored CAS latency field |
| mode_illegal_o | output | 1 | Stored length/order combination is illegal |

## Verification
A mode-register write is visible on `mode_o` and `mode_illegal_o` one cycle after the strobe's edge. A burst's beat 0 is due one cycle after the edge that samples `start_i`, and beat k follows k cycles later. `last_o` responds in the same cycle to `term_i`, while `valid_o` falls one cycle after the last beat. The bench drives inputs on the falling edge and checks each output a nanosecond later, so every result is read in the cycle in which it is due. Each beat's address is compared against a value computed from the start column, the beat index and the programmed order.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;
  localparam int BL_LSB    = 0;
  localparam int BL_W      = 3;
  localparam int ORDER_BIT = 3;
  localparam int CL_LSB    = 4;
  localparam int CL_W      = 3;

  localparam logic [BL_W-1:0] BL_1    = 3'b000;
  localparam logic [BL_W-1:0] BL_2    = 3'b001;
  localparam logic [BL_W-1:0] BL_4    = 3'b010;
  localparam logic [BL_W-1:0] BL_8    = 3'b011;
  localparam logic [BL_W-1:0] BL_FULL = 3'b111;

  typedef enum logic {
    ORD_SEQ   = 1'b0,
    ORD_INTLV = 1'b1
  } order_e;
endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg #(
  parameter int MODE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mrs_i,
  input  logic              banks_idle_i,
  input  logic [MODE_W-1:0] addr_i,
  output logic [MODE_W-1:0] mode_o
);
  logic              wr_en;
  logic [MODE_W-1:0] mode_q;

  assign wr_en  = mrs_i & banks_idle_i;
  assign mode_o = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mode_q <= '0;
    else if (wr_en) mode_q <= addr_i;
  end

  AST_MRS_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mrs_i && banks_idle_i) |=> (mode_o == $past(addr_i))); // R1

  AST_MRS_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mrs_i && banks_idle_i) |=> $stable(mode_o)); // R2
endmodule

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [BL_W-1:0]  bl_code_i,
  input  order_e           order_i,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o,
  output logic             illegal_o
);
  always_comb begin
    mask_o    = '0;
    full_o    = 1'b0;
    illegal_o = 1'b0;
    unique case (bl_code_i)
      BL_1: mask_o = '0;
      BL_2: mask_o = COL_W'(1);
      BL_4: mask_o = COL_W'(3);
      BL_8: mask_o = COL_W'(7);
      BL_FULL: begin
        if (order_i == ORD_INTLV) begin
          illegal_o = 1'b1;        // full page has no interleaved order
        end else begin
          mask_o = '1;
          full_o = 1'b1;
        end
      end
      default: illegal_o = 1'b1;
    endcase
  end

  always_comb begin
    if (illegal_o) assert (mask_o == '0 && !full_o); // R7
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             term_i,
  input  logic [COL_W-1:0] cfg_mask_i,
  input  order_e           cfg_order_i,
  input  logic             cfg_full_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  logic             active_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] cnt_q;
  logic [COL_W-1:0] mask_q;
  order_e           order_q;
  logic             full_q;
  logic [COL_W-1:0] seq_sum;

  assign seq_sum = base_q + cnt_q;

  always_comb begin
    if (order_q == ORD_INTLV) col_o = base_q ^ (cnt_q & mask_q);
    else                      col_o = (base_q & ~mask_q) | (seq_sum & mask_q);
  end

  assign valid_o = active_q;
  assign last_o  = active_q & (term_i | (!full_q && cnt_q == mask_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
      mask_q   <= '0;
      order_q  <= ORD_SEQ;
      full_q   <= 1'b0;
    end else if (start_i) begin
      // new burst wins over any running one
      active_q <= 1'b1;
      base_q   <= start_col_i;
      cnt_q    <= '0;
      mask_q   <= cfg_mask_i;
      order_q  <= cfg_order_i;
      full_q   <= cfg_full_i;
    end else if (active_q) begin
      if (last_o) active_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // checker-side next sequential address
  logic [COL_W-1:0] col_plus1;
  logic [COL_W-1:0] col_step;
  assign col_plus1 = col_o + 1'b1;
  assign col_step  = (col_plus1 & mask_q) | (col_o & ~mask_q);

  AST_START_BEAT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (valid_o && col_o == $past(start_col_i))); // R10

  AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o && !start_i && order_q == ORD_SEQ)
      |=> (col_o == $past(col_step))); // R4

  AST_INTLV_HIGH_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o && !start_i && order_q == ORD_INTLV)
      |=> (((col_o ^ $past(col_o)) & ~mask_q) == '0)); // R5

  AST_LAST_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && last_o && !start_i) |=> !valid_o); // R9

  AST_NOT_LAST_CONT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o) |=> valid_o); // R8
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import sdram_burst_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int MODE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mrs_i,
  input  logic              banks_idle_i,
  input  logic [MODE_W-1:0] addr_i,
  input  logic              start_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic              term_i,
  output logic [COL_W-1:0]  col_o,
  output logic              valid_o,
  output logic              last_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [CL_W-1:0]   cas_lat_o,
  output logic              mode_illegal_o
);
  logic [MODE_W-1:0] mode;
  logic [BL_W-1:0]   bl_code;
  order_e            order;
  logic [COL_W-1:0]  cfg_mask;
  logic              cfg_full;

  burst_mode_reg #(.MODE_W(MODE_W)) u_mode (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mrs_i        (mrs_i),
    .banks_idle_i (banks_idle_i),
    .addr_i       (addr_i),
    .mode_o       (mode)
  );

  assign bl_code   = mode[BL_LSB +: BL_W];
  assign order     = order_e'(mode[ORDER_BIT]);
  assign cas_lat_o = mode[CL_LSB +: CL_W];
  assign mode_o    = mode;

  burst_len_decode #(.COL_W(COL_W)) u_dec (
    .bl_code_i (bl_code),
    .order_i   (order),
    .mask_o    (cfg_mask),
    .full_o    (cfg_full),
    .illegal_o (mode_illegal_o)
  );

  burst_col_seq #(.COL_W(COL_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .term_i      (term_i),
    .cfg_mask_i  (cfg_mask),
    .cfg_order_i (order),
    .cfg_full_i  (cfg_full),
    .col_o       (col_o),
    .valid_o     (valid_o),
    .last_o      (last_o)
  );

  AST_ILLEGAL_ONE_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && mode_illegal_o) |=> (valid_o && last_o)); // R7
endmodule

// File: tb/sdram_burst_colgen_test.sv
module sdram_burst_colgen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mrs_i = 1'b0, banks_idle_i = 1'b0, start_i = 1'b0, term_i = 1'b0;
  logic [9:0] addr_i = '0;
  logic [8:0] start_col_i = '0;
  logic [8:0] col_o;
  logic       valid_o, last_o, mode_illegal_o;
  logic [9:0] mode_o;
  logic [2:0] cas_lat_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  sdram_burst_colgen uut (
    .clk_i(clk), .rst_ni(rst_n), .mrs_i(mrs_i), .banks_idle_i(banks_idle_i),
    .addr_i(addr_i), .start_i(start_i), .start_col_i(start_col_i), .term_i(term_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .mode_o(mode_o),
    .cas_lat_o(cas_lat_o), .mode_illegal_o(mode_illegal_o)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [8:0] exp_col(logic [8:0] s, int k, int len, bit intlv);
    logic [8:0] m;
    logic [8:0] sum;
    m = 9'(len - 1);
    sum = s + 9'(k);
    if (intlv) return s ^ (9'(k) & m);
    return (s & ~m) | (sum & m);
  endfunction

  task automatic do_mrs(logic [9:0] v, logic idle);
    @(negedge clk);
    mrs_i = 1'b1; addr_i = v; banks_idle_i = idle;
    @(negedge clk);
    mrs_i = 1'b0; banks_idle_i = 1'b0;
    #1;
  endtask

  task automatic pulse_start(logic [8:0] s);
    @(negedge clk);
    start_i = 1'b1; start_col_i = s;
  endtask

  // fixed-length burst, checked beat by beat; R4/R5/R8/R9
  task automatic run_fixed(string req, logic [8:0] s, int len, bit intlv);
    pulse_start(s);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      start_i = 1'b0;
      #1;
      chk(req, int'(col_o), int'(exp_col(s, k, len, intlv)));
      chk({req, " valid R8"}, int'(valid_o), 1);
      chk({req, " last R9"}, int'(last_o), (k == len - 1) ? 1 : 0);
    end
    @(negedge clk); #1;
    chk({req, " end R9"}, int'(valid_o), 0);
  endtask

  task automatic t_reset;
    #1;
    chk("R2 reset mode", int'(mode_o), 0);
    chk("R8 reset valid", int'(valid_o), 0);
    chk("R7 reset illegal", int'(mode_illegal_o), 0);
  endtask

  task automatic t_mrs;
    do_mrs(10'h35, 1'b1);
    chk("R1 mode load", int'(mode_o), 'h35);
    chk("R1 cas field", int'(cas_lat_o), 3);
    do_mrs(10'h3FF, 1'b0);
    chk("R2 gated mrs", int'(mode_o), 'h35);
  endtask

  task automatic t_seq;
    do_mrs(10'h020, 1'b1); run_fixed("R3 R8 len1", 9'd77, 1, 1'b0);
    do_mrs(10'h021, 1'b1); run_fixed("R4 seq2", 9'd13, 2, 1'b0);
    do_mrs(10'h022, 1'b1); run_fixed("R4 seq4", 9'd6, 4, 1'b0);
    do_mrs(10'h023, 1'b1); run_fixed("R4 seq8", 9'd45, 8, 1'b0);
    run_fixed("R4 seq8 top", 9'd511, 8, 1'b0);
  endtask

  task automatic t_intlv;
    do_mrs(10'h02A, 1'b1); run_fixed("R5 intlv4", 9'd6, 4, 1'b1);
    do_mrs(10'h02B, 1'b1); run_fixed("R5 intlv8", 9'd101, 8, 1'b1);
    do_mrs(10'h029, 1'b1); run_fixed("R5 intlv2", 9'd3, 2, 1'b1);
  endtask

  task automatic t_full;
    logic [8:0] s;
    s = 9'd509;
    do_mrs(10'h007, 1'b1);
    chk("R7 full seq legal", int'(mode_illegal_o), 0);
    pulse_start(s);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      start_i = 1'b0;
      term_i  = (k == 5);
      #1;
      chk("R6 full col", int'(col_o), int'(9'(s + 9'(k))));
      chk("R6 full last", int'(last_o), (k == 5) ? 1 : 0);
    end
    @(negedge clk); term_i = 1'b0; #1;
    chk("R6 full end", int'(valid_o), 0);
  endtask

  task automatic t_illegal;
    do_mrs(10'h004, 1'b1);
    chk("R7 code100", int'(mode_illegal_o), 1);
    run_fixed("R7 code100 burst", 9'd40, 1, 1'b0);
    do_mrs(10'h006, 1'b1);
    chk("R7 code110", int'(mode_illegal_o), 1);
    do_mrs(10'h00F, 1'b1);
    chk("R7 intlv full", int'(mode_illegal_o), 1);
    run_fixed("R7 intlv full burst", 9'd200, 1, 1'b1);
  endtask

  task automatic t_abort;
    do_mrs(10'h003, 1'b1);
    pulse_start(9'd5);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      start_i = (k == 2);
      start_col_i = 9'd20;
      #1;
      chk("R10 before abort", int'(col_o), int'(exp_col(9'd5, k, 8, 1'b0)));
    end
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); start_i = 1'b0; #1;
      chk("R10 new burst", int'(col_o), int'(exp_col(9'd20, k, 8, 1'b0)));
      chk("R10 new last", int'(last_o), (k == 7) ? 1 : 0);
    end
    @(negedge clk); #1;
    chk("R10 end", int'(valid_o), 0);
  endtask

  task automatic t_term_fixed;
    do_mrs(10'h003, 1'b1);
    pulse_start(9'd30);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      start_i = 1'b0;
      term_i = (k == 3);
      #1;
      chk("R11 col", int'(col_o), int'(exp_col(9'd30, k, 8, 1'b0)));
      chk("R11 last", int'(last_o), (k == 3) ? 1 : 0);
    end
    @(negedge clk); term_i = 1'b0; #1;
    chk("R11 end", int'(valid_o), 0);
  endtask

  task automatic t_capture;
    do_mrs(10'h002, 1'b1);
    pulse_start(9'd9);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      start_i = 1'b0;
      mrs_i = (k == 0); banks_idle_i = (k == 0); addr_i = 10'h00B;
      #1;
      chk("R12 col", int'(col_o), int'(exp_col(9'd9, k, 4, 1'b0)));
      chk("R12 last", int'(last_o), (k == 3) ? 1 : 0);
    end
    @(negedge clk); mrs_i = 1'b0; banks_idle_i = 1'b0; #1;
    chk("R12 end", int'(valid_o), 0);
    chk("R12 mode took", int'(mode_o), 'h00B);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_mrs();
    t_seq();
    t_intlv();
    t_full();
    t_illegal();
    t_abort();
    t_term_fixed();
    t_capture();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule